// File: doc/BRIEF.md
# Word-to-Character Unpacking Register

This block sits between a word holding buffer and a character-oriented peripheral. It accepts 24-bit words through a valid/ready handshake and sends each one out as a stream of 6-bit characters. A 2-bit setting chooses how many characters each word carries, from one to four. Characters always leave from the top of an internal shift register, and the register moves left by one character after each transfer. Only the chosen number of characters is sent. Whatever remains of the word is then discarded and the next word is fetched.

The setting is captured when a word is loaded, so software may change it at any time without corrupting a word in flight. If the buffer has no word ready, the character output goes idle and stays idle until a word arrives. A stop request ends the transfer at once. The held word and its remaining characters are thrown away, and no new word is taken while the request is high. When the last character of a word and a new word are accepted in the same cycle, the next character appears with no idle cycle between them.

Top module: `wpk_unpacker`

## Requirements
- R1: After reset, `char_valid` is 0, `char_data` is 0, and `word_ready` is 1 while `stop_req` is low.
- R2: The `cpw_sel` value captured at a word load sets the number of characters sent from that word: 0 sends one, 1 sends two, 2 sends three, 3 sends four.
- R3: Character k of a word (k counted from 0) is `word_data[23-6k : 18-6k]`, so `word_data[23:18]` is sent first.
- R4: Once the selected number of characters has been accepted, the rest of the word is discarded and the next character comes from a newly loaded word.
- R5: While `char_valid` is 1, `char_ready` is 0 and `stop_req` is low, the next cycle keeps `char_valid` at 1 and `char_data` unchanged.
- R6: When no word is held, `char_valid` stays 0 until a word is accepted. The first character appears in the cycle after the word is accepted.
- R7: A change of `cpw_sel` while a word is held does not alter the number of characters sent from that word.
- R8: While `stop_req` is 1, `word_ready` is 0. In the cycle after `stop_req` is seen high, `char_valid` is 0, and characters of the discarded word are never sent.
- R9: If `stop_req` is low, `word_ready` is 1 in any cycle where the last character of the held word is accepted. This lets words flow back to back without an idle cycle.
- R10: `char_data` is 0 whenever `char_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | Holding buffer offers a word |
| word_ready | output | 1 | Block takes the offered word on this edge |
| word_data | input | 24 | Word from the holding buffer |
| cpw_sel | input | 2 | Characters per word minus one, captured at load |
| stop_req | input | 1 | End the transfer and drop the held word |
| char_valid | output | 1 | A character is presented to the peripheral |
| char_ready | input | 1 | Peripheral accepts the character on this edge |
| char_data | output | 6 | Character presented to the peripheral |

## Verification
The embedded properties assume that `char_ready` and `stop_req` are plain synchronous levels. They also assume that `word_data` and `cpw_sel` are stable whenever `word_valid` is sampled at an edge. The bench drives every input on the falling edge, so each input is a clean level by the next rising edge. The bench also changes `cpw_sel` only between loads or in deliberate mid-word tests. The stall property is gated by `stop_req`, because a stop may legally withdraw a character that was still waiting for `char_ready`.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

   localparam int unsigned WPK_DEF_CHAR_W = 6;
   localparam int unsigned WPK_DEF_CHARS  = 4;

   // Width of a counter able to hold 0 .. n.
   function automatic int unsigned wpk_cnt_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // Width of the characters-per-word selector for up to n characters.
   function automatic int unsigned wpk_sel_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wpk_cpw_decode.sv
module wpk_cpw_decode #(
   parameter int unsigned CHARS_MAX   = wpk_pkg::WPK_DEF_CHARS,
   parameter bit          SEL_PLUS_ONE = 1'b1,
   localparam int unsigned SEL_W = wpk_pkg::wpk_sel_width(CHARS_MAX),
   localparam int unsigned CNT_W = wpk_pkg::wpk_cnt_width(CHARS_MAX)
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] count
);

   generate
      if (SEL_PLUS_ONE) begin : g_plus_one
         // Selector holds the count minus one.
         always_comb count = CNT_W'(sel) + CNT_W'(1);
      end else begin : g_zero_is_max
         // Selector holds the count directly; zero stands for the maximum.
         always_comb count = (sel == '0) ? CNT_W'(CHARS_MAX) : CNT_W'(sel);
      end
   endgenerate

   always_comb begin
      if (count != '0) begin
         a_r2_count_nonzero : assert (count <= CNT_W'(CHARS_MAX));
      end
   end

endmodule

// File: rtl/wpk_char_counter.sv
module wpk_char_counter #(
   parameter int unsigned CHARS_MAX = wpk_pkg::WPK_DEF_CHARS,
   localparam int unsigned CNT_W = wpk_pkg::wpk_cnt_width(CHARS_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_count,
   input  logic             step,
   output logic             busy,
   output logic             last
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (clear) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_count;
      end else if (step && (left_q != '0)) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign busy = (left_q != '0);
   assign last = (left_q == CNT_W'(1));

   a_r4_left_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= CNT_W'(CHARS_MAX));

   a_r4_step_counts_down : assert property (@(posedge clk) disable iff (!rst_n)
      (step && busy && !load && !clear) |=> (left_q == $past(left_q) - CNT_W'(1)));

   a_r8_clear_empties : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !busy);

endmodule

// File: rtl/wpk_shift_word.sv
module wpk_shift_word #(
   parameter int unsigned CHAR_W    = wpk_pkg::WPK_DEF_CHAR_W,
   parameter int unsigned CHARS_MAX = wpk_pkg::WPK_DEF_CHARS,
   localparam int unsigned WORD_W = CHAR_W * CHARS_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   output logic [CHAR_W-1:0] head
);

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (clear) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= load_word;
      end else if (shift) begin
         word_q <= word_q << CHAR_W;
      end
   end

   assign head = word_q[WORD_W-1 -: CHAR_W];

   generate
      if (CHARS_MAX > 1) begin : g_shift_chk
         a_r3_next_char_moves_up : assert property (@(posedge clk) disable iff (!rst_n)
            (shift && !load && !clear) |=> (head == $past(word_q[WORD_W-CHAR_W-1 -: CHAR_W])));
      end
   endgenerate

   a_r3_load_presents_top : assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> (head == $past(load_word[WORD_W-1 -: CHAR_W])));

endmodule

// File: rtl/wpk_unpacker.sv
module wpk_unpacker #(
   parameter int unsigned CHAR_W       = wpk_pkg::WPK_DEF_CHAR_W,
   parameter int unsigned CHARS_MAX    = wpk_pkg::WPK_DEF_CHARS,
   parameter bit          SEL_PLUS_ONE = 1'b1,
   parameter bit          ZERO_IDLE    = 1'b1,
   localparam int unsigned WORD_W = CHAR_W * CHARS_MAX,
   localparam int unsigned SEL_W  = wpk_pkg::wpk_sel_width(CHARS_MAX),
   localparam int unsigned CNT_W  = wpk_pkg::wpk_cnt_width(CHARS_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   output logic              word_ready,
   input  logic [WORD_W-1:0] word_data,
   input  logic [SEL_W-1:0]  cpw_sel,
   input  logic              stop_req,
   output logic              char_valid,
   input  logic              char_ready,
   output logic [CHAR_W-1:0] char_data
);

   generate
      if (CHAR_W < 1) begin : g_bad_char_w
         $error("wpk_unpacker: CHAR_W must be at least 1");
      end
      if (CHARS_MAX < 1) begin : g_bad_chars
         $error("wpk_unpacker: CHARS_MAX must be at least 1");
      end
      if (SEL_PLUS_ONE && ((1 << SEL_W) < CHARS_MAX)) begin : g_bad_sel
         $error("wpk_unpacker: selector too narrow for CHARS_MAX");
      end
   endgenerate

   logic             busy;
   logic             last;
   logic             fire;
   logic             take;
   logic [CNT_W-1:0] load_count;
   logic [CHAR_W-1:0] head;

   assign fire       = char_valid && char_ready;
   assign word_ready = !stop_req && (!busy || (fire && last));
   assign take       = word_valid && word_ready;
   assign char_valid = busy;

   wpk_cpw_decode #(
      .CHARS_MAX   (CHARS_MAX),
      .SEL_PLUS_ONE(SEL_PLUS_ONE)
   ) decode_i (
      .sel  (cpw_sel),
      .count(load_count)
   );

   wpk_char_counter #(
      .CHARS_MAX(CHARS_MAX)
   ) counter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (stop_req),
      .load      (take),
      .load_count(load_count),
      .step      (fire),
      .busy      (busy),
      .last      (last)
   );

   wpk_shift_word #(
      .CHAR_W   (CHAR_W),
      .CHARS_MAX(CHARS_MAX)
   ) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (stop_req),
      .load     (take),
      .load_word(word_data),
      .shift    (fire),
      .head     (head)
   );

   generate
      if (ZERO_IDLE) begin : g_mask_idle
         assign char_data = busy ? head : '0;
      end else begin : g_raw_head
         assign char_data = head;
      end
   endgenerate

   a_r5_stall_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !char_ready && !stop_req) |=> (char_valid && $stable(char_data)));

   a_r8_stop_drops : assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !char_valid);

   a_r6_valid_needs_word : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(char_valid) |-> $past(word_valid && word_ready));

   a_r9_no_bubble : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last && word_valid && !stop_req) |=> char_valid);

   generate
      if (ZERO_IDLE) begin : g_idle_chk
         a_r10_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
            !char_valid |-> (char_data == '0));
      end
   endgenerate

endmodule

// File: tb/wpk_unpacker_tb.sv
`timescale 1ns/1ps
module wpk_unpacker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_valid = 1'b0;
   logic        word_ready;
   logic [23:0] word_data = '0;
   logic [1:0]  cpw_sel = '0;
   logic        stop_req = 1'b0;
   logic        char_valid;
   logic        char_ready = 1'b0;
   logic [5:0]  char_data;

   int checks = 0;
   int failures = 0;
   int stall_waits = 0;
   int rdy_mode = 2;
   bit done = 1'b0;
   logic [5:0] exp_q[$];

   always #2 clk = ~clk;

   wpk_unpacker dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_valid(word_valid),
      .word_ready(word_ready),
      .word_data (word_data),
      .cpw_sel   (cpw_sel),
      .stop_req  (stop_req),
      .char_valid(char_valid),
      .char_ready(char_ready),
      .char_data (char_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Driver: offer a word, wait for acceptance, push its expected characters (R2, R3).
   task automatic send_word(input logic [23:0] w, input logic [1:0] sel, input int post_sel);
      @(negedge clk);
      word_data  = w;
      cpw_sel    = sel;
      word_valid = 1'b1;
      #1;
      while (!word_ready) begin
         stall_waits++;
         @(negedge clk);
         #1;
      end
      for (int k = 0; k <= int'(sel); k++) exp_q.push_back(w[23-6*k -: 6]);
      @(posedge clk);
      #0.5;
      if (post_sel >= 0) cpw_sel = 2'(post_sel);
   endtask

   task automatic idle_word();
      @(negedge clk);
      word_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 2000 && (exp_q.size() != 0 || char_valid); i++) @(negedge clk);
      #3;
      chk(exp_q.size() == 0, "R4", "all expected characters delivered", exp_q.size(), 0);
   endtask

   // Ready generator
   initial begin
      forever begin
         @(negedge clk);
         if (rdy_mode == 0) char_ready = 1'b1;
         else if (rdy_mode == 1) char_ready = (($urandom % 3) != 0);
      end
   end

   // Monitor / scoreboard
   initial begin
      bit         prev_stall = 1'b0;
      bit         prev_stop = 1'b0;
      logic [5:0] prev_data = '0;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && !done) begin
            if (prev_stall && !prev_stop)
               chk(char_valid && (char_data == prev_data), "R5", "stalled character held",
                   int'(char_data), int'(prev_data));
            if (!char_valid)
               chk(char_data == '0, "R10", "idle data zero", int'(char_data), 0);
            if (char_valid && char_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4", "unexpected character", int'(char_data), 0);
               end else begin
                  logic [5:0] e;
                  e = exp_q.pop_front();
                  chk(char_data == e, "R3", "character value", int'(char_data), int'(e));
               end
            end
            prev_stall = char_valid && !char_ready;
            prev_stop  = stop_req;
            prev_data  = char_data;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit seen;
      int waits0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(char_valid == 1'b0, "R1", "char_valid after reset", char_valid, 0);
      chk(char_data == '0, "R1", "char_data after reset", char_data, 0);
      chk(word_ready == 1'b1, "R1", "word_ready after reset", word_ready, 1);

      // R6: nothing offered, nothing sent
      rdy_mode = 0;
      seen = 1'b0;
      repeat (8) begin
         @(negedge clk);
         #1;
         if (char_valid) seen = 1'b1;
      end
      chk(!seen, "R6", "no character without a word", seen, 0);

      // R2/R3: each setting with ready always high
      for (int s = 0; s < 4; s++) begin
         for (int j = 0; j < 3; j++) send_word(24'($urandom), 2'(s), -1);
         idle_word();
         drain();
      end
      send_word(24'hFC0FC0, 2'd3, -1);
      idle_word();
      drain();

      // R5: peripheral back-pressure with random ready
      rdy_mode = 1;
      for (int j = 0; j < 40; j++) send_word(24'($urandom), 2'($urandom), -1);
      idle_word();
      drain();

      // R9: back-to-back one-character words with ready high
      rdy_mode = 0;
      send_word(24'h111111, 2'd0, -1);
      waits0 = stall_waits;
      for (int j = 0; j < 6; j++) begin
         send_word(24'($urandom), 2'd0, -1);
         chk(char_valid == 1'b1, "R9", "no idle cycle between words", char_valid, 1);
      end
      chk(stall_waits == waits0, "R9", "word_ready at last character", stall_waits - waits0, 0);
      idle_word();
      drain();

      // R7: setting changed mid-word
      rdy_mode = 2;
      @(negedge clk);
      char_ready = 1'b0;
      send_word(24'hABCDEF, 2'd3, 0);
      repeat (3) @(negedge clk);
      rdy_mode = 0;
      send_word(24'h5A5A5A, 2'd0, -1);
      idle_word();
      drain();
      chk(1'b1, "R7", "four characters then one (scoreboard)", 1, 1);

      // R8: stop request
      rdy_mode = 2;
      @(negedge clk);
      char_ready = 1'b0;
      send_word(24'h123456, 2'd3, -1);
      @(negedge clk);
      char_ready = 1'b1;
      @(negedge clk);
      char_ready = 1'b0;
      stop_req   = 1'b1;
      word_data  = 24'h777777;
      word_valid = 1'b1;
      #1;
      chk(word_ready == 1'b0, "R8", "word_ready during stop", word_ready, 0);
      @(negedge clk);
      #1;
      chk(char_valid == 1'b0, "R8", "char_valid after stop", char_valid, 0);
      chk(word_ready == 1'b0, "R8", "word_ready still blocked", word_ready, 0);
      exp_q.delete();
      @(negedge clk);
      stop_req   = 1'b0;
      word_valid = 1'b0;
      char_ready = 1'b1;
      seen = 1'b0;
      repeat (5) begin
         @(negedge clk);
         #1;
         if (char_valid) seen = 1'b1;
      end
      chk(!seen, "R8", "dropped characters never sent", seen, 0);

      // R1 again: ready to accept after stop
      rdy_mode = 0;
      send_word(24'h0F0F0F, 2'd1, -1);
      idle_word();
      drain();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule